// File: doc/BRIEF.md
# PCI Interrupt Line Router

This block steers four shared PCI interrupt lines onto sixteen inputs of a legacy interrupt controller. Each shared line owns one byte-wide route register. A route value below sixteen names the controller input the line drives. Any larger value leaves the line unrouted.

Internally the block keeps a level map with one bit per (controller input, line) pair. The bit for input `i` and line `l` sits at index `i*4 + l`. Each controller output is the OR of the four bits of its input, so several lines may share one output without masking each other. When a write touches any route byte, the whole map is cleared and rebuilt from the present line levels under the new routing.

Two lookups are available to the rest of the system. The first is a routing query: given a line, it reports whether the line is enabled and which output it drives. The second is the slot swizzle, which turns a device number and an INTx pin into the shared line that the device's pin lands on.

Top module: `pirq_router`

## Requirements
- R1: After reset all sixteen outputs are low and every route register holds 0x80, so the query reports every line disabled with `query_irq` = 0xFF, even while line levels are high.
- R2: A write updates route byte k (bits 8k+7:8k of `wr_data`) only when `wr_be[k]` is set; route bytes whose enable is clear keep their values.
- R3: For the line chosen by `query_pin`, a route value below 16 gives `query_en`=1 and `query_irq` equal to the route value. A value of 16 or more gives `query_en`=0 and `query_irq`=0xFF (minus one).
- R4: A level change on a routed line appears on `irq_out[route]` after exactly one rising clock edge, and not before it.
- R5: Each output is the OR of the levels of all lines currently routed to it; with every line low, every output falls low one edge later.
- R6: A line whose route value is 16 or more drives no output, whatever its level.
- R7: After a write that touches any route byte, the edge that samples the write still leaves the outputs on the old routing. From the next edge on, the outputs follow the new routing, and outputs no longer routed drop.
- R8: A write whose byte enables are all zero, or any cycle with `wr_en` low, leaves every route register unchanged.
- R9: `slot_line` equals (`slot_pin` + `slot_dev` - 1) mod 4 combinationally, so device 0 maps pin p to line (p+3) mod 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Route register write strobe |
| wr_be | input | 4 | Byte enable per route register |
| wr_data | input | 32 | Route bytes, byte k for line k |
| line_lvl | input | 4 | Level of each shared interrupt line |
| irq_out | output | 16 | Registered controller input levels |
| query_pin | input | 2 | Line selected for the routing query |
| query_en | output | 1 | Selected line is routed |
| query_irq | output | 8 | Routed output number, 0xFF when unrouted |
| slot_dev | input | 5 | Device number for the swizzle |
| slot_pin | input | 2 | INTx pin of the device (0 = A) |
| slot_line | output | 2 | Shared line the pin lands on |

## Verification
The bench uses the default parameters: four lines, sixteen outputs, 8-bit route bytes and a 5-bit device number. This configuration is small enough to drive every line through every route value from 0 to 31, plus 0x80 and 0xFF, and to query all four lines after each single-byte write. It also applies all sixteen level combinations under many shared and partly unrouted route sets, and checks the old routing on the write edge and the new routing on the edge after it. All 128 device and pin pairs of the swizzle are checked as well.

// File: rtl/pirq_router_pkg.sv
package pirq_router_pkg;
    localparam int         DEF_LINES     = 4;
    localparam int         DEF_IRQS      = 16;
    localparam int         DEF_ROUTE_W   = 8;
    localparam int         DEF_DEV_W     = 5;
    localparam logic [7:0] DEF_ROUTE_RST = 8'h80;
endpackage

// File: rtl/pirq_route_regs.sv
module pirq_route_regs #(
    parameter int                 NUM_LINES = 4,
    parameter int                 ROUTE_W   = 8,
    parameter logic [ROUTE_W-1:0] ROUTE_RST = 8'h80
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [NUM_LINES-1:0]           wr_be,
    input  logic [NUM_LINES*ROUTE_W-1:0]   wr_data,
    output logic [NUM_LINES*ROUTE_W-1:0]   route_o,
    output logic                           rebuild_o
);
    localparam int ALL_W = NUM_LINES * ROUTE_W;

    typedef struct packed {
        logic [ALL_W-1:0] route;
        logic             rebuild;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.rebuild = wr_en && (|wr_be);
        for (int k = 0; k < NUM_LINES; k++) begin
            if (wr_en && wr_be[k]) begin
                st_d.route[k*ROUTE_W +: ROUTE_W] = wr_data[k*ROUTE_W +: ROUTE_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.route   <= {NUM_LINES{ROUTE_RST}};
            st_q.rebuild <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign route_o   = st_q.route;
    assign rebuild_o = st_q.rebuild;

    // R7
    route_change_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(route_o) |-> rebuild_o);

    // R8
    no_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (|wr_be)) |=> $stable(route_o));
endmodule

// File: rtl/pirq_level_map.sv
module pirq_level_map #(
    parameter int NUM_LINES = 4,
    parameter int NUM_IRQS  = 16,
    parameter int ROUTE_W   = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_LINES*ROUTE_W-1:0] route_i,
    input  logic                         rebuild_i,
    input  logic [NUM_LINES-1:0]         line_lvl,
    output logic [NUM_IRQS-1:0]          irq_o
);
    localparam int                 MAP_W     = NUM_IRQS * NUM_LINES;
    localparam int                 IRQ_W     = $clog2(NUM_IRQS);
    localparam logic [ROUTE_W-1:0] IRQ_LIMIT = ROUTE_W'(NUM_IRQS);

    typedef struct packed {
        logic [MAP_W-1:0]    map;
        logic [NUM_IRQS-1:0] irq;
    } map_t;

    map_t st_d, st_q;

    always_comb begin
        int                 idx;
        logic [ROUTE_W-1:0] sel;
        idx  = 0;
        sel  = '0;
        st_d = st_q;
        if (rebuild_i) begin
            st_d.map = '0;
        end
        for (int l = 0; l < NUM_LINES; l++) begin
            sel = route_i[l*ROUTE_W +: ROUTE_W];
            if (sel < IRQ_LIMIT) begin
                idx = int'(sel[IRQ_W-1:0]) * NUM_LINES + l;
                st_d.map[idx] = line_lvl[l];
            end
        end
        for (int i = 0; i < NUM_IRQS; i++) begin
            st_d.irq[i] = |st_d.map[i*NUM_LINES +: NUM_LINES];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_o = st_q.irq;

    logic [NUM_LINES-1:0] line_any;
    always_comb begin
        line_any = '0;
        for (int l = 0; l < NUM_LINES; l++) begin
            for (int i = 0; i < NUM_IRQS; i++) begin
                line_any[l] = line_any[l] | st_q.map[i*NUM_LINES + l];
            end
        end
    end

    for (genvar l = 0; l < NUM_LINES; l++) begin : g_line_chk
        // R6
        unrouted_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rebuild_i && !(route_i[l*ROUTE_W +: ROUTE_W] < IRQ_LIMIT)) |=> !line_any[l]);
    end

    // R5
    idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_lvl == '0) |=> (irq_o == '0));
endmodule

// File: rtl/pirq_slot_swizzle.sv
module pirq_slot_swizzle #(
    parameter int LINE_W = 2,
    parameter int DEV_W  = 5
) (
    input  logic [DEV_W-1:0]  slot_dev,
    input  logic [LINE_W-1:0] slot_pin,
    output logic [LINE_W-1:0] slot_line
);
    logic [LINE_W-1:0] dev_lo;

    always_comb begin
        dev_lo    = slot_dev[LINE_W-1:0];
        slot_line = slot_pin + dev_lo - LINE_W'(1);
    end
endmodule

// File: rtl/pirq_router.sv
module pirq_router
    import pirq_router_pkg::*;
#(
    parameter int                 NUM_LINES = DEF_LINES,
    parameter int                 NUM_IRQS  = DEF_IRQS,
    parameter int                 ROUTE_W   = DEF_ROUTE_W,
    parameter int                 DEV_W     = DEF_DEV_W,
    parameter logic [ROUTE_W-1:0] ROUTE_RST = DEF_ROUTE_RST,
    localparam int                LINE_W    = $clog2(NUM_LINES)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [NUM_LINES-1:0]         wr_be,
    input  logic [NUM_LINES*ROUTE_W-1:0] wr_data,
    input  logic [NUM_LINES-1:0]         line_lvl,
    output logic [NUM_IRQS-1:0]          irq_out,
    input  logic [LINE_W-1:0]            query_pin,
    output logic                         query_en,
    output logic [ROUTE_W-1:0]           query_irq,
    input  logic [DEV_W-1:0]             slot_dev,
    input  logic [LINE_W-1:0]            slot_pin,
    output logic [LINE_W-1:0]            slot_line
);
    localparam int                 IRQ_W     = $clog2(NUM_IRQS);
    localparam logic [ROUTE_W-1:0] IRQ_LIMIT = ROUTE_W'(NUM_IRQS);

    logic [NUM_LINES*ROUTE_W-1:0] route_q;
    logic                         rebuild_q;
    logic [ROUTE_W-1:0]           qsel;

    pirq_route_regs #(
        .NUM_LINES (NUM_LINES),
        .ROUTE_W   (ROUTE_W),
        .ROUTE_RST (ROUTE_RST)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_be     (wr_be),
        .wr_data   (wr_data),
        .route_o   (route_q),
        .rebuild_o (rebuild_q)
    );

    pirq_level_map #(
        .NUM_LINES (NUM_LINES),
        .NUM_IRQS  (NUM_IRQS),
        .ROUTE_W   (ROUTE_W)
    ) u_map (
        .clk       (clk),
        .rst_n     (rst_n),
        .route_i   (route_q),
        .rebuild_i (rebuild_q),
        .line_lvl  (line_lvl),
        .irq_o     (irq_out)
    );

    pirq_slot_swizzle #(
        .LINE_W (LINE_W),
        .DEV_W  (DEV_W)
    ) u_swz (
        .slot_dev  (slot_dev),
        .slot_pin  (slot_pin),
        .slot_line (slot_line)
    );

    always_comb begin
        qsel      = route_q[int'(query_pin)*ROUTE_W +: ROUTE_W];
        query_en  = qsel < IRQ_LIMIT;
        query_irq = query_en ? ROUTE_W'(qsel[IRQ_W-1:0]) : '1;
    end

    for (genvar l = 0; l < NUM_LINES; l++) begin : g_follow_chk
        // R4
        level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (line_lvl[l] && (route_q[l*ROUTE_W +: ROUTE_W] < IRQ_LIMIT))
            |=> irq_out[$past(route_q[l*ROUTE_W +: IRQ_W])]);
    end
endmodule

// File: tb/sim_pirq_router.sv
`timescale 1ns/1ps
module sim_pirq_router;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_be = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  line_lvl = '0;
    logic [15:0] irq_out;
    logic [1:0]  query_pin = '0;
    logic        query_en;
    logic [7:0]  query_irq;
    logic [4:0]  slot_dev = '0;
    logic [1:0]  slot_pin = '0;
    logic [1:0]  slot_line;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;
    logic [7:0] rt [4];

    always #2 clk = ~clk;

    pirq_router u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_be     (wr_be),
        .wr_data   (wr_data),
        .line_lvl  (line_lvl),
        .irq_out   (irq_out),
        .query_pin (query_pin),
        .query_en  (query_en),
        .query_irq (query_irq),
        .slot_dev  (slot_dev),
        .slot_pin  (slot_pin),
        .slot_line (slot_line)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_irq(input logic [3:0] lv);
        logic [15:0] r = '0;
        for (int k = 0; k < 4; k++) begin
            if (lv[k] && rt[k] < 8'd16) r[rt[k][3:0]] = 1'b1;
        end
        return r;
    endfunction

    task automatic check_queries(input string req);
        for (int p = 0; p < 4; p++) begin
            query_pin = 2'(p);
            #1;
            if (rt[p] < 8'd16) begin
                check(req, {31'd0, query_en}, 32'd1);
                check(req, {24'd0, query_irq}, {24'd0, rt[p]});
            end else begin
                check(req, {31'd0, query_en}, 32'd0);
                check(req, {24'd0, query_irq}, 32'hFF);
            end
        end
    endtask

    // Write routes; checks old routing on the sampling edge and new one after it (R7)
    task automatic write_routes(input logic [3:0] be, input logic [31:0] data, input bit chk_old);
        logic [15:0] old_exp;
        old_exp = exp_irq(line_lvl);
        @(negedge clk);
        wr_en = 1'b1; wr_be = be; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0; wr_be = '0;
        for (int k = 0; k < 4; k++) if (be[k]) rt[k] = data[k*8 +: 8];
        if (chk_old) check("R7 old routing on write edge", {16'd0, irq_out}, {16'd0, old_exp});
        @(negedge clk);
        check("R7 new routing after rebuild", {16'd0, irq_out}, {16'd0, exp_irq(line_lvl)});
    endtask

    task automatic set_lvl(input logic [3:0] v, input string req);
        @(negedge clk);
        line_lvl = v;
        @(negedge clk);
        check(req, {16'd0, irq_out}, {16'd0, exp_irq(line_lvl)});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 4; k++) rt[k] = 8'h80;
        line_lvl = 4'hF;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        // R1 reset state, R6 high lines unrouted
        check("R1 outputs low after reset", {16'd0, irq_out}, 32'd0);
        check_queries("R1 reset route value");

        // R8 write with no byte enabled
        @(negedge clk);
        wr_en = 1'b1; wr_be = 4'b0000; wr_data = 32'h0302_0100;
        @(negedge clk);
        wr_en = 1'b0;
        @(negedge clk);
        check("R8 zero byte enables ignored", {16'd0, irq_out}, 32'd0);
        check_queries("R8 routes unchanged");

        // R2 R3 R4 R6 single-line sweep over route values
        for (int k = 0; k < 4; k++) begin
            set_lvl(4'b0001 << k, "R4 single line level");
            for (int v = 0; v < 34; v++) begin
                logic [7:0] rv;
                rv = (v == 32) ? 8'h80 : (v == 33) ? 8'hFF : 8'(v);
                write_routes(4'b0001 << k, 32'(rv) << (8 * k), 1'b0);
                check("R6 R4 single routed line", {16'd0, irq_out}, {16'd0, exp_irq(line_lvl)});
                check_queries("R2 R3 byte-enabled query");
            end
            write_routes(4'b0001 << k, 32'h80 << (8 * k), 1'b0);
        end

        // R4 one-edge latency, not earlier
        write_routes(4'hF, 32'h8080_8005, 1'b0);
        set_lvl(4'h0, "R5 all low");
        @(negedge clk);
        line_lvl = 4'b0001;
        #1;
        check("R4 not before edge", {16'd0, irq_out}, 32'd0);
        @(negedge clk);
        check("R4 after one edge", {16'd0, irq_out}, 32'h20);

        // R5 all lines share one output
        write_routes(4'hF, 32'h0303_0303, 1'b1);
        for (int lv = 0; lv < 16; lv++) set_lvl(4'(lv), "R5 shared output");

        // R5 R6 R7 mixed route sets
        for (int t = 0; t < 48; t++) begin
            logic [31:0] d;
            d = '0;
            for (int k = 0; k < 4; k++) d[k*8 +: 8] = 8'((t * 7 + k * 5 + (t >> 2)) % 20);
            set_lvl(4'hF, "R5 all high before write");
            write_routes(4'hF, d, 1'b1);
            for (int lv = 0; lv < 16; lv++) set_lvl(4'(lv), "R5 R6 level combination");
        end

        // R9 slot swizzle exhaustive
        for (int dv = 0; dv < 32; dv++) begin
            for (int p = 0; p < 4; p++) begin
                slot_dev = 5'(dv); slot_pin = 2'(p);
                #1;
                check("R9 slot swizzle", {30'd0, slot_line}, 32'((p + dv + 3) % 4));
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule